// File: doc/BRIEF.md
# Serial Core Operating-State Controller

This block holds the operating state of a serial mini-core and produces the flags that tell software when a FIFO needs attention. The state is one of three codes (running, paused, held in reset), and a valid indication sits beside it. Software may request a new state only while valid is high. After each accepted request, valid stays low for a fixed settling time and then returns once the new state is in effect. Leaving the paused state for reset is guarded: it takes two accepted reset requests in a row. A separate software-reset pulse forces the reset state at any time.

The same block keeps sticky service flags. The output flag is raised when the output FIFO drains, meaning its not-empty indication falls. The input flag is raised while received data is waiting. Both are cleared by writing 1. A set of error flags captures engine error events for the enabled positions and is also write-1-to-clear. While the core sits in reset, both FIFOs are flushed and every flag is held clear. The protocol engine may consume FIFO words only while the core is running with valid high.

Top module: `core_state_ctrl`

## Requirements
- R1: After `rst_n` deasserts, `state_code` is RESET, `state_valid` is 1, `fifo_flush` is 1, and all service flags, `err_flags` and `err_en` are 0.
- R2: State codes are RUN=2'b01, RESET=2'b10 and PAUSE=2'b11. A request on `state_wr` is accepted only when `state_valid` is 1 and the code is not 2'b00. Otherwise it has no effect.
- R3: An accepted request that changes state updates `state_code` at the capturing edge. `state_valid` then reads 0 for exactly two cycles and 1 on the third.
- R4: From PAUSE, the first accepted RESET request leaves the state PAUSE with valid still 1, and the next accepted RESET request moves to RESET. If a different code is accepted in between, the pending request is cancelled and that code takes effect.
- R5: A `sw_reset` pulse forces RESET, cancels any pending request, drops `state_valid` for two cycles, and wins over a simultaneous `state_wr`.
- R6: The output service flag (`op_status[2]`) is set in the cycle after `ofifo_ne` goes from 1 to 0. It stays set until `svc_clr[0]` is written 1, and a new set wins over a clear in the same cycle. A steady low `ofifo_ne` does not set it again.
- R7: The input service flag (`op_status[3]`) is set after any cycle in which `ififo_avail` is 1. It is cleared by `svc_clr[1]`, and set wins over clear.
- R8: Error flags occupy bits 6:2 of `err_flags`. A bit sets when the matching `err_evt` bit is 1 while the same `err_en` bit is 1. It clears when `err_clr` writes 1 to it. `err_en` is loaded by `err_en_wr`. Bits 1:0 of both always read 0.
- R9: While `state_code` is RESET, `fifo_flush` is 1 and every flag is cleared on the next edge. `engine_run` is 1 only in RUN with `state_valid` 1.
- R10: `op_status[0]` and `op_status[1]` follow `ofifo_ne` and `ofifo_full` in the same cycle.
- R11: `err_irq` is 1 exactly when some bit is set in both `err_flags` and `err_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_wr | input | 1 | State change request strobe |
| state_wr_code | input | 2 | Requested state code |
| sw_reset | input | 1 | Software reset pulse |
| svc_clr | input | 2 | Write-1-to-clear for the service flags (bit0 output, bit1 input) |
| err_clr | input | 7 | Write-1-to-clear for the error flags |
| err_en_wr | input | 1 | Load strobe for the error enable register |
| err_en_data | input | 7 | New error enable value |
| err_evt | input | 7 | Error event pulses from the engine |
| ofifo_ne | input | 1 | Output FIFO not empty |
| ofifo_full | input | 1 | Output FIFO full |
| ififo_avail | input | 1 | Received data waiting in the input FIFO |
| state_code | output | 2 | Current state code |
| state_valid | output | 1 | State settled; requests allowed |
| engine_run | output | 1 | Engine may consume FIFO words |
| fifo_flush | output | 1 | Flush both FIFOs |
| op_status | output | 4 | {in flag, out flag, out full, out not empty} |
| err_flags | output | 7 | Sticky error flags |
| err_en | output | 7 | Error enable register |
| err_irq | output | 1 | Enabled error pending |

## Verification
If the settling counter is wrong, `state_valid` rises a cycle early or late after a request. A following request is then accepted or dropped, so the state code diverges within three cycles. If the pending-reset bit is lost or gets stuck, the second RESET request from PAUSE has the wrong effect: the core either stays paused or enters reset early, and both show at once on `state_code` and `fifo_flush`. If a flag is cleared or set at the wrong time, it shows on `op_status` or `err_flags` one edge after the stimulus. The reference model compares every output on every cycle, so none of these errors can stay hidden for more than one clock.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam logic [1:0] CODE_RUN   = 2'b01;
    localparam logic [1:0] CODE_RESET = 2'b10;
    localparam logic [1:0] CODE_PAUSE = 2'b11;

    function automatic logic code_legal(input logic [1:0] c);
        return c != 2'b00;
    endfunction
endpackage

// File: rtl/csc_state_ctrl.sv
module csc_state_ctrl
    import csc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [1:0] wr_code,
    input  logic       sw_reset,
    output logic [1:0] state_code,
    output logic       valid
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYCLES);

    typedef struct packed {
        logic [1:0]    state;
        logic [CW-1:0] cnt;
        logic          armed;
    } st_t;

    st_t cur_q, nxt_d;
    logic wr_take, arm_only;

    assign valid      = (cur_q.cnt == '0);
    assign state_code = cur_q.state;
    assign wr_take    = wr_req && valid && code_legal(wr_code);
    assign arm_only   = wr_take && (cur_q.state == CODE_PAUSE) &&
                        (wr_code == CODE_RESET) && !cur_q.armed;

    always_comb begin
        nxt_d = cur_q;
        if (sw_reset) begin
            nxt_d.state = CODE_RESET;
            nxt_d.cnt   = SETTLE_LD;
            nxt_d.armed = 1'b0;
        end else if (wr_take) begin
            if (arm_only) begin
                nxt_d.armed = 1'b1;
            end else begin
                nxt_d.state = wr_code;
                nxt_d.cnt   = SETTLE_LD;
                nxt_d.armed = 1'b0;
            end
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= CODE_RESET;
            cur_q.cnt   <= '0;
            cur_q.armed <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assert_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && !arm_only) |=> !valid);

    assert_change_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != $past(state_code)) |-> $past(wr_take || sw_reset));

    assert_pause_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_only && !sw_reset) |=> (state_code == CODE_PAUSE) && valid);

    assert_swreset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (state_code == CODE_RESET) && !valid);
endmodule

// File: rtl/csc_svc_flags.sv
module csc_svc_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_clr,
    input  logic       ofifo_ne,
    input  logic       ififo_avail,
    input  logic [1:0] clr,
    output logic       out_svc,
    output logic       in_svc
);
    typedef struct packed {
        logic ne_prev;
        logic osvc;
        logic isvc;
    } sv_t;

    sv_t fl_q, fl_d;
    logic drained;

    assign drained = fl_q.ne_prev && !ofifo_ne;

    always_comb begin
        fl_d         = fl_q;
        fl_d.ne_prev = ofifo_ne;
        if (hold_clr) begin
            fl_d.osvc = 1'b0;
            fl_d.isvc = 1'b0;
        end else begin
            fl_d.osvc = drained     || (fl_q.osvc && !clr[0]);
            fl_d.isvc = ififo_avail || (fl_q.isvc && !clr[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign out_svc = fl_q.osvc;
    assign in_svc  = fl_q.isvc;

    assert_osvc_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ne_prev && !ofifo_ne && !hold_clr) |=> out_svc);

    assert_isvc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ififo_avail && !hold_clr) |=> in_svc);

    assert_svc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (!out_svc && !in_svc));
endmodule

// File: rtl/csc_err_flags.sv
module csc_err_flags #(
    parameter int ERR_W  = 7,
    parameter int ERR_LO = 2,
    parameter int ERR_HI = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic [ERR_W-1:0] evt,
    input  logic [ERR_W-1:0] clr,
    input  logic             en_wr,
    input  logic [ERR_W-1:0] en_data,
    output logic [ERR_W-1:0] flags,
    output logic [ERR_W-1:0] en,
    output logic             irq
);
    logic [ERR_W-1:0] field_mask;

    for (genvar i = 0; i < ERR_W; i++) begin : g_mask
        assign field_mask[i] = (i >= ERR_LO) && (i <= ERR_HI);
    end

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [ERR_W-1:0] en;
    } er_t;

    er_t er_q, er_d;
    logic [ERR_W-1:0] hits;

    assign hits = evt & er_q.en;

    always_comb begin
        er_d = er_q;
        if (hold_clr) er_d.err = '0;
        else          er_d.err = (hits | (er_q.err & ~clr)) & field_mask;
        if (en_wr)    er_d.en  = en_data & field_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) er_q <= '0;
        else        er_q <= er_d;
    end

    assign flags = er_q.err;
    assign en    = er_q.en;
    assign irq   = |(er_q.err & er_q.en);

    assert_err_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hits != '0) && !hold_clr) |=> ((flags & $past(hits)) == $past(hits)));

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (flags == '0));
endmodule

// File: rtl/core_state_ctrl.sv
module core_state_ctrl
    import csc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2,
    parameter int ERR_W         = 7,
    parameter int ERR_LO        = 2,
    parameter int ERR_HI        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             state_wr,
    input  logic [1:0]       state_wr_code,
    input  logic             sw_reset,
    input  logic [1:0]       svc_clr,
    input  logic [ERR_W-1:0] err_clr,
    input  logic             err_en_wr,
    input  logic [ERR_W-1:0] err_en_data,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             ofifo_ne,
    input  logic             ofifo_full,
    input  logic             ififo_avail,
    output logic [1:0]       state_code,
    output logic             state_valid,
    output logic             engine_run,
    output logic             fifo_flush,
    output logic [3:0]       op_status,
    output logic [ERR_W-1:0] err_flags,
    output logic [ERR_W-1:0] err_en,
    output logic             err_irq
);
    logic hold_clr, out_svc, in_svc;

    csc_state_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (state_wr),
        .wr_code    (state_wr_code),
        .sw_reset   (sw_reset),
        .state_code (state_code),
        .valid      (state_valid)
    );

    assign hold_clr   = (state_code == CODE_RESET) || sw_reset;
    assign fifo_flush = (state_code == CODE_RESET);
    assign engine_run = (state_code == CODE_RUN) && state_valid;

    csc_svc_flags u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_clr    (hold_clr),
        .ofifo_ne    (ofifo_ne),
        .ififo_avail (ififo_avail),
        .clr         (svc_clr),
        .out_svc     (out_svc),
        .in_svc      (in_svc)
    );

    csc_err_flags #(.ERR_W(ERR_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (hold_clr),
        .evt      (err_evt),
        .clr      (err_clr),
        .en_wr    (err_en_wr),
        .en_data  (err_en_data),
        .flags    (err_flags),
        .en       (err_en),
        .irq      (err_irq)
    );

    assign op_status = {in_svc, out_svc, ofifo_full, ofifo_ne};

    assert_run_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_wr && state_valid && state_wr_code == CODE_RUN && state_code != CODE_PAUSE
         && !sw_reset) |=> !engine_run);
endmodule

// File: tb/core_state_ctrl_test.sv
module core_state_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       state_wr = 1'b0;
    logic [1:0] state_wr_code = 2'b00;
    logic       sw_reset = 1'b0;
    logic [1:0] svc_clr = 2'b00;
    logic [6:0] err_clr = '0;
    logic       err_en_wr = 1'b0;
    logic [6:0] err_en_data = '0;
    logic [6:0] err_evt = '0;
    logic       ofifo_ne = 1'b0;
    logic       ofifo_full = 1'b0;
    logic       ififo_avail = 1'b0;
    logic [1:0] state_code;
    logic       state_valid, engine_run, fifo_flush, err_irq;
    logic [3:0] op_status;
    logic [6:0] err_flags, err_en;

    core_state_ctrl uut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int m_state = 2, m_cnt = 0, m_armed = 0, m_neprev = 0;
    int m_osvc = 0, m_isvc = 0, m_err = 0, m_en = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int n_state, n_cnt, n_armed, n_osvc, n_isvc, n_err, n_en;
        bit take, clr_all;
        if (!rst_n) begin
            n_state = 2; n_cnt = 0; n_armed = 0; n_osvc = 0; n_isvc = 0; n_err = 0; n_en = 0;
        end else begin
            n_state = m_state; n_cnt = m_cnt; n_armed = m_armed; n_en = m_en;
            take = state_wr && (m_cnt == 0) && (state_wr_code != 2'b00);
            clr_all = (m_state == 2) || sw_reset;
            if (sw_reset) begin
                n_state = 2; n_cnt = 2; n_armed = 0;
            end else if (take) begin
                if (m_state == 3 && state_wr_code == 2'b10 && m_armed == 0) n_armed = 1;
                else begin n_state = int'(state_wr_code); n_cnt = 2; n_armed = 0; end
            end else if (m_cnt > 0) n_cnt = m_cnt - 1;
            if (clr_all) begin
                n_osvc = 0; n_isvc = 0; n_err = 0;
            end else begin
                n_osvc = ((m_neprev == 1) && !ofifo_ne) || ((m_osvc == 1) && !svc_clr[0]);
                n_isvc = ififo_avail || ((m_isvc == 1) && !svc_clr[1]);
                n_err  = ((int'(err_evt) & m_en) | (m_err & ~int'(err_clr))) & 'h7C;
            end
            if (err_en_wr) n_en = int'(err_en_data) & 'h7C;
        end
        m_neprev <= rst_n ? int'(ofifo_ne) : 0;
        m_state <= n_state; m_cnt <= n_cnt; m_armed <= n_armed;
        m_osvc <= n_osvc; m_isvc <= n_isvc; m_err <= n_err; m_en <= n_en;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "model state_code", int'(state_code), m_state);
            chk("R3", "model state_valid", int'(state_valid), int'(m_cnt == 0));
            chk("R9", "model engine_run", int'(engine_run), int'(m_state == 1 && m_cnt == 0));
            chk("R9", "model fifo_flush", int'(fifo_flush), int'(m_state == 2));
            chk("R6", "model out flag", int'(op_status[2]), m_osvc);
            chk("R7", "model in flag", int'(op_status[3]), m_isvc);
            chk("R10", "model fifo status", int'(op_status[1:0]), (int'(ofifo_full) << 1) | int'(ofifo_ne));
            chk("R8", "model err_flags", int'(err_flags), m_err);
            chk("R8", "model err_en", int'(err_en), m_en);
            chk("R11", "model err_irq", int'(err_irq), int'((m_err & m_en) != 0));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] code);
        state_wr = 1'b1; state_wr_code = code;
        step();
        state_wr = 1'b0;
    endtask

    task automatic settle();
        step(); step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "reset state", int'(state_code), 2);
        chk("R1", "reset valid", int'(state_valid), 1);
        chk("R1", "reset flush", int'(fifo_flush), 1);
        chk("R1", "reset err", int'(err_flags), 0);

        // R3 RUN request and settling
        wr(2'b01);
        chk("R3", "state after RUN", int'(state_code), 1);
        chk("R3", "valid low 1", int'(state_valid), 0);
        step();
        chk("R3", "valid low 2", int'(state_valid), 0);
        step();
        chk("R3", "valid back", int'(state_valid), 1);
        chk("R9", "engine_run", int'(engine_run), 1);

        // R2 request while not valid is ignored
        wr(2'b01);
        wr(2'b11);
        step(); step();
        chk("R2", "ignored during settle", int'(state_code), 1);
        // R2 illegal code ignored
        wr(2'b00);
        chk("R2", "code 00 ignored", int'(state_code), 1);
        chk("R2", "code 00 keeps valid", int'(state_valid), 1);

        // R10 passthrough
        ofifo_ne = 1'b1; ofifo_full = 1'b1; #1;
        chk("R10", "status full/ne", int'(op_status[1:0]), 3);
        step();
        ofifo_full = 1'b0; ofifo_ne = 1'b0;
        step();
        // R6 falling edge sets out flag
        chk("R6", "out flag set", int'(op_status[2]), 1);
        svc_clr = 2'b01; step(); svc_clr = 2'b00;
        chk("R6", "out flag cleared", int'(op_status[2]), 0);
        step();
        chk("R6", "no re-set on low level", int'(op_status[2]), 0);

        // R7 input flag
        ififo_avail = 1'b1; step(); ififo_avail = 1'b0;
        chk("R7", "in flag set", int'(op_status[3]), 1);
        step();
        chk("R7", "in flag sticky", int'(op_status[3]), 1);
        svc_clr = 2'b10; step(); svc_clr = 2'b00;
        chk("R7", "in flag cleared", int'(op_status[3]), 0);

        // R8 error flags
        err_en_wr = 1'b1; err_en_data = 7'h7F; step(); err_en_wr = 1'b0;
        chk("R8", "enable field", int'(err_en), 'h7C);
        err_evt = 7'h0F; step(); err_evt = '0;
        chk("R8", "err capture", int'(err_flags), 'h0C);
        chk("R11", "irq on", int'(err_irq), 1);
        err_clr = 7'h04; step(); err_clr = '0;
        chk("R8", "err w1c", int'(err_flags), 'h08);
        err_en_wr = 1'b1; err_en_data = 7'h00; step(); err_en_wr = 1'b0;
        chk("R11", "irq masked", int'(err_irq), 0);
        err_evt = 7'h10; step(); err_evt = '0;
        chk("R8", "disabled evt ignored", int'(err_flags), 'h08);

        // R4 two RESET writes from PAUSE
        wr(2'b11); settle();
        chk("R4", "in pause", int'(state_code), 3);
        wr(2'b10);
        chk("R4", "first reset holds pause", int'(state_code), 3);
        chk("R4", "first reset keeps valid", int'(state_valid), 1);
        wr(2'b10);
        chk("R4", "second reset enters reset", int'(state_code), 2);
        step();
        chk("R9", "flags cleared in reset", int'(err_flags), 0);
        chk("R9", "flush in reset", int'(fifo_flush), 1);
        step();

        // R4 cancel by other code
        wr(2'b01); settle();
        wr(2'b11); settle();
        wr(2'b10);
        wr(2'b01);
        chk("R4", "cancel goes run", int'(state_code), 1);
        settle();
        wr(2'b11); settle();
        wr(2'b10);
        chk("R4", "arm restarted", int'(state_code), 3);

        // R5 software reset wins over request
        sw_reset = 1'b1; state_wr = 1'b1; state_wr_code = 2'b01;
        step();
        sw_reset = 1'b0; state_wr = 1'b0;
        chk("R5", "sw reset state", int'(state_code), 2);
        chk("R5", "sw reset valid", int'(state_valid), 0);
        settle();
        chk("R5", "sw reset settled", int'(state_valid), 1);
        wr(2'b10);
        chk("R5", "pending cleared", int'(state_code), 2);
        settle();
        finish_run();
    end
endmodule